// File: doc/BRIEF.md
# Four-Cell Dot-Matrix Row Scanner

This block refreshes a row of four 5-column by 7-row LED character cells by lighting one row at a time. A free-running prescaler counts clock cycles; every time it completes a slot it steps a row counter through the seven rows and wraps back to the top. While a row is active, each cell gets a 5-bit column pattern. That pattern is either the glyph slice for the cell's stored 7-bit character code, or a solid cursor block.

Each cell's choice follows a shared cursor-enable pin and a per-cell cursor bit. Cursor dots are lit only for the first half of every row slot, so a cursor shows at half brightness. Toggling the pin makes it flash. Every cell's columns are then ANDed with that cell's enable from an external blanking controller. The font is a small combinational lookup with a few glyphs, intended to be swapped for a full table.

Top module: `dotscan_top`

## Requirements
- R1: `row_sel` always has exactly one bit set. After reset it is `7'b0000001` (bit r selects row r, row 0 is the top row).
- R2: The active row steps 0,1,...,6 and then wraps back to 0.
- R3: Each row stays selected for exactly `PRESCALE` (default 32) clock cycles.
- R4: With `cursor_en` = 0, every cell shows the glyph row of its stored code for the active row, whatever its cursor bit. Cell d uses code bits `char_codes[7d+6:7d]` and drives `col_out[5d+4:5d]`, with bit 5d+4 being the leftmost column. Cell 0 is the rightmost cell.
- R5: With `cursor_en` = 1 and `cursor_bits[d]` = 1, cell d lights all five columns during prescaler phases 0 to PRESCALE/2-1 of each row slot, and no columns during the remaining phases.
- R6: With `cursor_en` = 1, a cell whose cursor bit is 0 still shows its character glyph.
- R7: When `digit_en[d]` = 0, the columns of cell d are all 0, both for a character and for a cursor.
- R8: The font decodes all 7 code bits. 0x48 gives rows 10001 ×3, 11111, 10001 ×3. 0x49 gives 01110, then 00100 ×5, then 01110. 0x2D gives 11111 on row 3 and 0 elsewhere. 0x20 and every other code are blank, so 0x09 is blank although 0x49 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| char_codes | input | 28 | Four 7-bit character codes, cell 0 in the low bits |
| cursor_bits | input | 4 | Per-cell cursor select |
| cursor_en | input | 1 | Global cursor enable; pulse it to flash the cursor |
| digit_en | input | 4 | Per-cell enable from the blanking controller |
| row_sel | output | 7 | One-hot active row |
| col_out | output | 20 | Column drive, five bits per cell |

## Verification
The half-brightness window is the hardest case to reach. The cursor is lit only in the first half of each row slot, so a check must line up with the prescaler phase, and that phase never appears at the ports. The bench keeps its own phase and row counters, started from reset. It then checks each cell's columns on every cycle of a whole frame, with cursor and character cells mixed and with some cells disabled. It also looks for the bit-6 aliasing case by placing codes that differ only in their top bit side by side.

// File: rtl/dotscan_pkg.sv
package dotscan_pkg;

    localparam int CELL_COLS = 5;
    localparam int CELL_ROWS = 7;
    localparam int CODE_W    = 7;
    localparam int ROW_W     = $clog2(CELL_ROWS);

    typedef logic [CELL_COLS-1:0] col_bits_t;
    typedef logic [CODE_W-1:0]    char_code_t;
    typedef logic [ROW_W-1:0]     row_idx_t;

    typedef enum logic {
        SRC_GLYPH  = 1'b0,
        SRC_CURSOR = 1'b1
    } cell_src_e;

    // Replaceable font stub: code and row in, five columns out (MSB = leftmost).
    function automatic col_bits_t glyph_row(input char_code_t code, input row_idx_t row);
        col_bits_t bits;
        case (code)
            7'h48:   bits = (row == 3'd3) ? 5'b11111 : 5'b10001;
            7'h49:   bits = (row == 3'd0 || row == 3'd6) ? 5'b01110 : 5'b00100;
            7'h2D:   bits = (row == 3'd3) ? 5'b11111 : 5'b00000;
            default: bits = 5'b00000;
        endcase
        return bits;
    endfunction

endpackage

// File: rtl/dotscan_timebase.sv
module dotscan_timebase
    import dotscan_pkg::*;
#(
    parameter int PRESCALE = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    output row_idx_t             row_idx,
    output logic [CELL_ROWS-1:0] row_sel,
    output logic                 slot_end,
    output logic                 first_half
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [PW-1:0] PRE_HALF = PW'(PRESCALE / 2);
    localparam row_idx_t ROW_LAST = row_idx_t'(CELL_ROWS - 1);

    logic [PW-1:0] pre_q;
    row_idx_t      row_q;

    assign slot_end   = (pre_q == PRE_LAST);
    assign first_half = (pre_q < PRE_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            row_q <= '0;
        end else if (slot_end) begin
            pre_q <= '0;
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign row_idx = row_q;

    always_comb begin
        row_sel = '0;
        for (int r = 0; r < CELL_ROWS; r++) begin
            if (row_q == row_idx_t'(r)) row_sel[r] = 1'b1;
        end
    end

endmodule

// File: rtl/dotscan_cell.sv
module dotscan_cell
    import dotscan_pkg::*;
(
    input  char_code_t code,
    input  row_idx_t   row,
    input  logic       cursor_bit,
    input  logic       cursor_en,
    input  logic       first_half,
    input  logic       enable,
    output col_bits_t  cols
);
    cell_src_e src;
    col_bits_t raw;

    always_comb begin
        src = (cursor_en && cursor_bit) ? SRC_CURSOR : SRC_GLYPH;
        if (src == SRC_CURSOR) raw = first_half ? '1 : '0;
        else                   raw = glyph_row(code, row);
        cols = enable ? raw : '0;
    end

endmodule

// File: rtl/dotscan_top.sv
module dotscan_top
    import dotscan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int PRESCALE   = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_DIGITS*CODE_W-1:0]    char_codes,
    input  logic [NUM_DIGITS-1:0]           cursor_bits,
    input  logic                            cursor_en,
    input  logic [NUM_DIGITS-1:0]           digit_en,
    output logic [CELL_ROWS-1:0]            row_sel,
    output logic [NUM_DIGITS*CELL_COLS-1:0] col_out
);
    row_idx_t row_idx;
    logic     slot_end;
    logic     first_half;

    dotscan_timebase #(.PRESCALE(PRESCALE)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .row_idx    (row_idx),
        .row_sel    (row_sel),
        .slot_end   (slot_end),
        .first_half (first_half)
    );

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_cell
        dotscan_cell u_cell (
            .code       (char_codes[d*CODE_W +: CODE_W]),
            .row        (row_idx),
            .cursor_bit (cursor_bits[d]),
            .cursor_en  (cursor_en),
            .first_half (first_half),
            .enable     (digit_en[d]),
            .cols       (col_out[d*CELL_COLS +: CELL_COLS])
        );
    end

endmodule

// File: rtl/dotscan_checker.sv
module dotscan_checker
    import dotscan_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic [CELL_ROWS-1:0]            row_sel,
    input logic [NUM_DIGITS*CELL_COLS-1:0] col_out,
    input logic [NUM_DIGITS-1:0]           cursor_bits,
    input logic                            cursor_en,
    input logic [NUM_DIGITS-1:0]           digit_en,
    input logic                            slot_end,
    input logic                            first_half
);
    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(row_sel) == 1);

    assert_row_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (row_sel[CELL_ROWS-1] && slot_end) |=> row_sel[0]);

    assert_row_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(row_sel));

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_chk
        assert_cursor_dark_R5: assert property (@(posedge clk) disable iff (rst)
            (cursor_en && cursor_bits[d] && !first_half) |-> (col_out[d*CELL_COLS +: CELL_COLS] == '0));

        assert_cursor_lit_R5: assert property (@(posedge clk) disable iff (rst)
            (cursor_en && cursor_bits[d] && digit_en[d] && first_half) |-> (col_out[d*CELL_COLS +: CELL_COLS] == '1));

        assert_disabled_dark_R7: assert property (@(posedge clk) disable iff (rst)
            !digit_en[d] |-> (col_out[d*CELL_COLS +: CELL_COLS] == '0));
    end

endmodule

bind dotscan_top dotscan_checker #(.NUM_DIGITS(NUM_DIGITS)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .row_sel     (row_sel),
    .col_out     (col_out),
    .cursor_bits (cursor_bits),
    .cursor_en   (cursor_en),
    .digit_en    (digit_en),
    .slot_end    (slot_end),
    .first_half  (first_half)
);

// File: tb/dotscan_top_test.sv
`timescale 1ns/1ps
module dotscan_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] char_codes = '0;
    logic [3:0]  cursor_bits = '0;
    logic        cursor_en = 1'b0;
    logic [3:0]  digit_en = '0;
    logic [6:0]  row_sel;
    logic [19:0] col_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int ref_pre = 0;
    int ref_row = 0;

    always #4 clk = ~clk;

    dotscan_top uut (
        .clk(clk), .rst(rst), .char_codes(char_codes), .cursor_bits(cursor_bits),
        .cursor_en(cursor_en), .digit_en(digit_en), .row_sel(row_sel), .col_out(col_out)
    );

    // Independent phase/row model from R1-style spec values: 32 phases, 7 rows.
    always @(posedge clk) begin
        if (rst) begin
            ref_pre <= 0;
            ref_row <= 0;
        end else if (ref_pre == 31) begin
            ref_pre <= 0;
            ref_row <= (ref_row == 6) ? 0 : ref_row + 1;
        end else begin
            ref_pre <= ref_pre + 1;
        end
    end

    function automatic logic [4:0] font_ref(input logic [6:0] code, input int row);
        if (code == 7'h48) return (row == 3) ? 5'b11111 : 5'b10001;
        if (code == 7'h49) return (row == 0 || row == 6) ? 5'b01110 : 5'b00100;
        if (code == 7'h2D) return (row == 3) ? 5'b11111 : 5'b00000;
        return 5'b00000;
    endfunction

    function automatic logic [19:0] cols_ref();
        logic [19:0] v = '0;
        for (int d = 0; d < 4; d++) begin
            logic [4:0] c;
            if (cursor_en && cursor_bits[d]) c = (ref_pre < 16) ? 5'b11111 : 5'b00000;
            else c = font_ref(char_codes[d*7 +: 7], ref_row);
            if (!digit_en[d]) c = 5'b00000;
            v[d*5 +: 5] = c;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (row=%0d phase=%0d)", req, act, exp, ref_row, ref_pre);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_frame(input string req);
        for (int i = 0; i < 7 * 32; i++) begin
            @(negedge clk);
            check(req, {12'd0, col_out}, {12'd0, cols_ref()});
        end
    endtask

    task automatic test_reset();
        do_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset row", {25'd0, row_sel}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 row after first step", {25'd0, row_sel}, 32'h1);
    endtask

    task automatic test_scan();
        do_reset();
        for (int i = 0; i < 2 * 7 * 32; i++) begin
            @(negedge clk);
            check("R1 R2 row sequence", {25'd0, row_sel}, 32'h1 << ref_row);
        end
    endtask

    task automatic test_dwell();
        logic [6:0] prev;
        int cnt;
        do_reset();
        prev = row_sel;
        while (row_sel == prev) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            prev = row_sel;
            cnt = 0;
            while (row_sel == prev) begin
                @(negedge clk);
                cnt++;
            end
            check("R3 row dwell", cnt, 32);
        end
    endtask

    task automatic test_font();
        do_reset();
        digit_en = 4'hF;
        cursor_en = 1'b0;
        cursor_bits = 4'hF;          // ignored while cursor_en = 0 (R4)
        char_codes = {7'h20, 7'h2D, 7'h49, 7'h48};
        check_frame("R4 R8 glyphs");
        char_codes = {7'h09, 7'h49, 7'h08, 7'h48};
        check_frame("R8 bit6 decode");
    endtask

    task automatic test_cursor();
        do_reset();
        digit_en = 4'hF;
        cursor_en = 1'b1;
        cursor_bits = 4'b0101;
        char_codes = {7'h48, 7'h49, 7'h2D, 7'h48};
        check_frame("R5 R6 cursor mix");
        cursor_en = 1'b0;
        check_frame("R4 cursor pin low");
    endtask

    task automatic test_enable();
        do_reset();
        digit_en = 4'b1010;
        cursor_en = 1'b1;
        cursor_bits = 4'b0011;
        char_codes = {7'h48, 7'h48, 7'h49, 7'h49};
        check_frame("R7 gated cells");
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R7 cells 0 and 2 dark", {27'd0, col_out[14:10], 5'd0}, 32'd0);
            check("R7 cell 0 dark", {27'd0, col_out[4:0]}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_scan();
        test_dwell();
        test_font();
        test_cursor();
        test_enable();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule